// File: doc/BRIEF.md
# Inter-Bank Command Spacing Checker

This block sits beside a four-bank DDR SDRAM command bus and judges every command the controller issues, one per clock. It keeps a small per-bank view of the bank state (idle, row open, or closing under an auto-precharge burst) and a record of the latest plain read or write burst. With these it decides whether each new command is legal. The main concern is concurrent auto precharge. While one bank is finishing a READ or WRITE that closes its own row, other banks may take commands. How long they must wait depends on the burst type, the kind of command that follows, the CAS latency rounded up to whole clocks, the burst length and the write-to-read turnaround.

For each command the block reports one clock later with a single-cycle violation pulse and a 3-bit reason code. It also drives a per-bank status bit that is high while a bank has an open row or is still closing. A command that is flagged is treated as not accepted: it leaves the tracked state untouched. CAS latency, burst length and turnaround are static settings, and their values are latched into the counters at the moment a burst starts.

Top module: `ibsc_top`

## Requirements
- R1: After reset every bank status bit is 0 and no violation is reported.
- R2: ACT to an idle bank opens it and raises its status bit. ACT to an open or closing bank is reason 5. READ or WRITE to an idle bank is reason 5. PRE to an open bank closes it. PRE to an idle bank is accepted.
- R3: After a WRITE with auto precharge issued in cycle t, a READ to another bank in cycle t+k is reason 1 when k < 1 + BL/2 + tWTR.
- R4: After a WRITE with auto precharge issued in cycle t, a WRITE to another bank in cycle t+k is reason 1 when k < BL/2.
- R5: After a READ with auto precharge issued in cycle t, a READ to another bank is reason 1 when k < BL/2, and a WRITE to another bank is reason 1 when k < ceil(CL) + BL/2.
- R6: PRE or ACT to another bank is never held back by an auto-precharge burst; one cycle after it is enough.
- R7: A bank given a READ or WRITE with auto precharge in cycle t has its row closed at once. Its status bit stays 1 until cycle t+max(read window, write window) and is 0 from then on. Any ACT, READ, WRITE, PRE or BST aimed at it before then is reason 5.
- R8: AUTO REFRESH or LOAD MODE while any status bit is 1 is reason 2. With all banks idle, both are accepted.
- R9: While a plain (no auto precharge) burst is tracked, BST to a different bank is reason 3. BST to the bank of that burst ends the tracking, so an access in the opposite direction is accepted right after it.
- R10: After a plain READ in cycle t, a WRITE in cycle t+k with k < ceil(CL) + BL/2 is reason 4. After a plain WRITE, a READ with k < 1 + BL/2 + tWTR is reason 4.
- R11: When several rules fail at once, the reason follows the priority 5, then 2, then 3, then 1, then 4. A flagged command changes no bank or burst state.
- R12: Encodings. Command: NOP 0, ACT 1, READ 2, WRITE 3, PRE 4, BST 5, AUTO REFRESH 6, LOAD MODE 7. Reason codes: 0 none, 1 spacing, 2 not idle, 3 wrong-bank terminate, 4 read/write contention, 5 reserved sequence. CAS latency is given in half clocks (4, 5 or 6). Burst length select s gives BL = 2^(s+1). tWTR is 1 to 3 clocks. The violation pulse and the code appear in the cycle after the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one command per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Decoded command (R12 encoding) |
| bank_i | input | 2 | Target bank |
| ap_i | input | 1 | Auto precharge with READ/WRITE |
| cl_half_i | input | 3 | CAS latency in half clocks |
| bl_sel_i | input | 2 | Burst length select |
| twtr_i | input | 2 | Write-to-read turnaround in clocks |
| viol_o | output | 1 | Violation pulse for the previous command |
| viol_code_o | output | 3 | Reason code for the previous command |
| bank_open_o | output | 4 | Per-bank open-or-closing status |

## Verification
Some properties are checked on every cycle. A closing bank never holds an open row and never takes a command. The closing counters step down by one each clock. Refresh or mode load with any bank busy always yields reason 2. A wrong-bank terminate always yields reason 3. PRE always clears the status bit of the bank it targets. Other behaviour can only be shown by the bench's scenarios: the exact boundary cycles of each spacing window under different CAS latency, burst length and tWTR settings, the release of contention after a terminate, the priority among reasons, and the rule that a rejected command leaves no trace.

// File: rtl/ibsc_pkg.sv
// Package: shared encodings for the inter-bank command spacing checker.
// Assumes: commands arrive already decoded, one per clock.
package ibsc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5,
        CMD_REF = 3'd6,
        CMD_LMR = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE       = 3'd0,
        V_SPACING    = 3'd1,
        V_NOT_IDLE   = 3'd2,
        V_BST_BANK   = 3'd3,
        V_RW_CONTEND = 3'd4,
        V_SEQ        = 3'd5
    } viol_e;

endpackage

// File: rtl/ibsc_timing.sv
// Module: ibsc_timing
// Turns the static timing settings into counter load values. Each value is
// the minimum spacing in clocks minus one, so a counter at zero means the
// window is over. Assumes cl_half_i is 4..6 and twtr_i is 1..3.
module ibsc_timing #(
    parameter int CNT_W = 5
) (
    input  logic [2:0]       cl_half_i,
    input  logic [1:0]       bl_sel_i,
    input  logic [1:0]       twtr_i,
    output logic [CNT_W-1:0] rd_after_rd_o,
    output logic [CNT_W-1:0] rd_after_wr_o,
    output logic [CNT_W-1:0] wr_after_rd_o,
    output logic [CNT_W-1:0] wr_after_wr_o
);

    logic [CNT_W-1:0] half_bl;
    logic [CNT_W-1:0] cl_up;
    logic [3:0]       cl_sum;

    // Derive the data-beat clocks, the rounded CAS latency and the four windows.
    always_comb begin
        half_bl       = CNT_W'(1) << bl_sel_i;
        cl_sum        = {1'b0, cl_half_i} + 4'd1;
        cl_up         = CNT_W'(cl_sum >> 1);
        rd_after_rd_o = half_bl - CNT_W'(1);
        wr_after_wr_o = half_bl - CNT_W'(1);
        rd_after_wr_o = half_bl + CNT_W'(twtr_i);
        wr_after_rd_o = cl_up + half_bl - CNT_W'(1);
    end

endmodule

// File: rtl/ibsc_bank.sv
// Module: ibsc_bank
// State of one bank: a row-open flag and two down-counters that run while
// an auto-precharge burst closes the bank. One counter bounds READs to other
// banks, the other bounds WRITEs. The bank is busy while either is nonzero.
// Assumes the judge never sends ACT/PRE/burst to a busy bank.
module ibsc_bank #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_set_i,
    input  logic             pre_clr_i,
    input  logic             ap_load_i,
    input  logic [CNT_W-1:0] rd_ld_i,
    input  logic [CNT_W-1:0] wr_ld_i,
    output logic             row_open_o,
    output logic             busy_o,
    output logic             rd_hold_o,
    output logic             wr_hold_o
);

    logic [CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0] wr_cnt;
    logic             row_q;

    // Load the windows on an auto-precharge burst, else count down and track the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
            row_q  <= 1'b0;
        end else if (ap_load_i) begin
            rd_cnt <= rd_ld_i;
            wr_cnt <= wr_ld_i;
            row_q  <= 1'b0;
        end else begin
            if (rd_cnt != '0) rd_cnt <= rd_cnt - 1'b1;
            if (wr_cnt != '0) wr_cnt <= wr_cnt - 1'b1;
            if (act_set_i)      row_q <= 1'b1;
            else if (pre_clr_i) row_q <= 1'b0;
        end
    end

    assign row_open_o = row_q;
    assign rd_hold_o  = (rd_cnt != '0);
    assign wr_hold_o  = (wr_cnt != '0);
    assign busy_o     = rd_hold_o | wr_hold_o;

    assert_closed_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !row_q);

    assert_no_cmd_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(act_set_i || pre_clr_i || ap_load_i));

    assert_rd_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt != '0 && !ap_load_i) |=> (rd_cnt == $past(rd_cnt) - 1'b1));

    assert_wr_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt != '0 && !ap_load_i) |=> (wr_cnt == $past(wr_cnt) - 1'b1));

endmodule

// File: rtl/ibsc_tracker.sv
// Module: ibsc_tracker
// Follows the latest plain READ or WRITE burst. It keeps its direction, its
// bank and a counter for how long an opposite-direction access stays in
// contention. A burst with auto precharge loads zero, which ends tracking.
module ibsc_tracker #(
    parameter int CNT_W = 5,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             ld_wr_i,
    input  logic [BA_W-1:0]  ld_bank_i,
    output logic             live_o,
    output logic             is_wr_o,
    output logic [BA_W-1:0]  bank_o
);

    logic [CNT_W-1:0] cnt;

    // Capture a new burst, end it on terminate, otherwise let the window run out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            is_wr_o <= 1'b0;
            bank_o  <= '0;
        end else if (load_i) begin
            cnt     <= ld_val_i;
            is_wr_o <= ld_wr_i;
            bank_o  <= ld_bank_i;
        end else if (clear_i) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign live_o = (cnt != '0);

    assert_clear_ends_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !load_i) |=> !live_o);

endmodule

// File: rtl/ibsc_judge.sv
// Module: ibsc_judge
// Combinational rule check for the current command against bank and burst
// state. It returns one reason code, picked by fixed priority:
// sequence, not idle, wrong-bank terminate, spacing, contention.
module ibsc_judge
    import ibsc_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input  cmd_e             cmd_i,
    input  logic [BA_W-1:0]  bank_i,
    input  logic [NB-1:0]    row_open_i,
    input  logic [NB-1:0]    busy_i,
    input  logic [NB-1:0]    rd_hold_i,
    input  logic [NB-1:0]    wr_hold_i,
    input  logic             trk_live_i,
    input  logic             trk_wr_i,
    input  logic [BA_W-1:0]  trk_bank_i,
    output viol_e            code_o
);

    logic [NB-1:0] self_sel;
    logic          other_rd;
    logic          other_wr;
    logic          self_busy;
    logic          self_open;
    logic          any_active;

    // Gather the facts the rules need about the target bank and the others.
    always_comb begin
        self_sel   = NB'(1) << bank_i;
        other_rd   = |(rd_hold_i & ~self_sel);
        other_wr   = |(wr_hold_i & ~self_sel);
        self_busy  = |(busy_i & self_sel);
        self_open  = |(row_open_i & self_sel);
        any_active = |(row_open_i | busy_i);
    end

    // Apply the rules per command in priority order.
    always_comb begin
        code_o = V_NONE;
        case (cmd_i)
            CMD_ACT: if (self_busy || self_open) code_o = V_SEQ;
            CMD_RD: begin
                if (self_busy || !self_open)        code_o = V_SEQ;
                else if (other_rd)                  code_o = V_SPACING;
                else if (trk_live_i && trk_wr_i)    code_o = V_RW_CONTEND;
            end
            CMD_WR: begin
                if (self_busy || !self_open)        code_o = V_SEQ;
                else if (other_wr)                  code_o = V_SPACING;
                else if (trk_live_i && !trk_wr_i)   code_o = V_RW_CONTEND;
            end
            CMD_PRE: if (self_busy) code_o = V_SEQ;
            CMD_BST: begin
                if (self_busy)                                 code_o = V_SEQ;
                else if (trk_live_i && trk_bank_i != bank_i)   code_o = V_BST_BANK;
            end
            CMD_REF, CMD_LMR: if (any_active) code_o = V_NOT_IDLE;
            default: code_o = V_NONE;
        endcase
    end

endmodule

// File: rtl/ibsc_top.sv
// Module: ibsc_top
// Inter-bank command spacing checker. Judges each command on the bus, reports
// the outcome one clock later, and updates the bank and burst state only for
// commands that pass. Assumes timing settings change only between commands.
module ibsc_top
    import ibsc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic                         ap_i,
    input  logic [2:0]                   cl_half_i,
    input  logic [1:0]                   bl_sel_i,
    input  logic [1:0]                   twtr_i,
    output logic                         viol_o,
    output logic [2:0]                   viol_code_o,
    output logic [NUM_BANKS-1:0]         bank_open_o
);

    localparam int BA_W = $clog2(NUM_BANKS);

    cmd_e             cmd;
    viol_e            code;
    logic             ok;
    logic             is_rdwr;
    logic [CNT_W-1:0] rd_after_rd, rd_after_wr, wr_after_rd, wr_after_wr;
    logic [CNT_W-1:0] bank_rd_ld, bank_wr_ld, trk_ld;
    logic [NUM_BANKS-1:0] row_open, busy, rd_hold, wr_hold;
    logic             trk_live, trk_wr;
    logic [BA_W-1:0]  trk_bank;

    assign cmd = cmd_e'(cmd_i);

    ibsc_timing #(.CNT_W(CNT_W)) u_timing (
        .cl_half_i     (cl_half_i),
        .bl_sel_i      (bl_sel_i),
        .twtr_i        (twtr_i),
        .rd_after_rd_o (rd_after_rd),
        .rd_after_wr_o (rd_after_wr),
        .wr_after_rd_o (wr_after_rd),
        .wr_after_wr_o (wr_after_wr)
    );

    ibsc_judge #(.NB(NUM_BANKS), .BA_W(BA_W)) u_judge (
        .cmd_i      (cmd),
        .bank_i     (bank_i),
        .row_open_i (row_open),
        .busy_i     (busy),
        .rd_hold_i  (rd_hold),
        .wr_hold_i  (wr_hold),
        .trk_live_i (trk_live),
        .trk_wr_i   (trk_wr),
        .trk_bank_i (trk_bank),
        .code_o     (code)
    );

    // Select the windows to load, by burst direction, for the banks and the tracker.
    always_comb begin
        ok         = (code == V_NONE);
        is_rdwr    = (cmd == CMD_RD) || (cmd == CMD_WR);
        bank_rd_ld = (cmd == CMD_WR) ? rd_after_wr : rd_after_rd;
        bank_wr_ld = (cmd == CMD_WR) ? wr_after_wr : wr_after_rd;
        trk_ld     = ap_i ? '0 : ((cmd == CMD_WR) ? rd_after_wr : wr_after_rd);
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = ok && (bank_i == BA_W'(g));
        ibsc_bank #(.CNT_W(CNT_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_set_i  (hit && cmd == CMD_ACT),
            .pre_clr_i  (hit && cmd == CMD_PRE),
            .ap_load_i  (hit && is_rdwr && ap_i),
            .rd_ld_i    (bank_rd_ld),
            .wr_ld_i    (bank_wr_ld),
            .row_open_o (row_open[g]),
            .busy_o     (busy[g]),
            .rd_hold_o  (rd_hold[g]),
            .wr_hold_o  (wr_hold[g])
        );
    end

    ibsc_tracker #(.CNT_W(CNT_W), .BA_W(BA_W)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ok && is_rdwr),
        .clear_i   (ok && cmd == CMD_BST && trk_live),
        .ld_val_i  (trk_ld),
        .ld_wr_i   (cmd == CMD_WR),
        .ld_bank_i (bank_i),
        .live_o    (trk_live),
        .is_wr_o   (trk_wr),
        .bank_o    (trk_bank)
    );

    // Register the verdict so it appears as a one-cycle pulse after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o      <= 1'b0;
            viol_code_o <= 3'd0;
        end else begin
            viol_o      <= !ok;
            viol_code_o <= code;
        end
    end

    assign bank_open_o = row_open | busy;

    assert_cfg_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_half_i >= 3'd4 && cl_half_i <= 3'd6 && twtr_i != 2'd0));

    assert_code_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_code_o != 3'd0 && viol_code_o <= 3'd5));

    assert_not_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_REF || cmd == CMD_LMR) && (|bank_open_o)) |=> (viol_code_o == 3'd2));

    assert_bst_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST && trk_live && trk_bank != bank_i && !busy[bank_i])
        |=> (viol_code_o == 3'd3));

    assert_pre_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && !busy[bank_i]) |=> !bank_open_o[$past(bank_i)]);

endmodule

// File: tb/tb_ibsc_top.sv
// Bench for ibsc_top: directed corner cases plus seeded random traffic,
// checked against a timestamp model built from the requirements.
module tb_ibsc_top;

    localparam int NB = 4;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, BST = 3'd5, REF = 3'd6, LMR = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = NOP;
    logic [1:0] bank = 2'd0;
    logic       ap = 1'b0;
    logic [2:0] clh = 3'd5;
    logic [1:0] bls = 2'd1;
    logic [1:0] twtr = 2'd2;
    logic       viol;
    logic [2:0] vcode;
    logic [3:0] bopen;

    always #5 clk = ~clk;

    ibsc_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
        .cl_half_i(clh), .bl_sel_i(bls), .twtr_i(twtr),
        .viol_o(viol), .viol_code_o(vcode), .bank_open_o(bopen)
    );

    int total = 0, bad = 0, cyc = 0;
    int ap_t[NB], ap_r[NB], ap_w[NB];
    bit row[NB];
    int trk_t = -1000, trk_min = 0, trk_bank = 0;
    bit trk_wr = 0;

    function automatic int bh();   return 1 << bls;         endfunction
    function automatic int clru(); return (int'(clh) + 1) / 2; endfunction
    function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

    function automatic bit busy_m(int i, int t);
        return (t - ap_t[i]) < mx(ap_r[i], ap_w[i]);
    endfunction

    function automatic bit live_m();
        return (cyc - trk_t) < trk_min;
    endfunction

    // Expected reason code for a command issued in model cycle cyc.
    function automatic int exp_code(logic [2:0] c, int b);
        int code = 0;
        bit orr = 0, ow = 0, anyb = 0;
        for (int i = 0; i < NB; i++) begin
            if (i != b && (cyc - ap_t[i]) < ap_r[i]) orr = 1;
            if (i != b && (cyc - ap_t[i]) < ap_w[i]) ow = 1;
            if (row[i] || busy_m(i, cyc)) anyb = 1;
        end
        case (c)
            ACT: if (busy_m(b, cyc) || row[b]) code = 5;
            RD: begin
                if (busy_m(b, cyc) || !row[b]) code = 5;
                else if (orr)                  code = 1;
                else if (live_m() && trk_wr)   code = 4;
            end
            WR: begin
                if (busy_m(b, cyc) || !row[b]) code = 5;
                else if (ow)                   code = 1;
                else if (live_m() && !trk_wr)  code = 4;
            end
            PRE: if (busy_m(b, cyc)) code = 5;
            BST: begin
                if (busy_m(b, cyc))                    code = 5;
                else if (live_m() && trk_bank != b)    code = 3;
            end
            REF, LMR: if (anyb) code = 2;
            default: code = 0;
        endcase
        return code;
    endfunction

    // Apply an accepted command to the model.
    task automatic model_update(logic [2:0] c, int b, bit a, int code);
        if (code != 0) return;
        case (c)
            ACT: row[b] = 1;
            PRE: row[b] = 0;
            BST: if (live_m()) trk_min = 0;
            RD, WR: begin
                if (a) begin
                    ap_t[b] = cyc;
                    row[b]  = 0;
                    ap_r[b] = (c == WR) ? 1 + bh() + int'(twtr) : bh();
                    ap_w[b] = (c == WR) ? bh() : clru() + bh();
                end
                trk_t    = cyc;
                trk_min  = a ? 0 : ((c == RD) ? clru() + bh() : 1 + bh() + int'(twtr));
                trk_wr   = (c == WR);
                trk_bank = b;
            end
            default: ;
        endcase
    endtask

    task automatic chk(bit good, string tag, string what, int act, int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // One command: drive at a falling edge, check the verdict at the next falling edge.
    task automatic step(logic [2:0] c, int b, bit a, string tag);
        int e;
        logic [3:0] eo;
        cmd  = c;
        bank = b[1:0];
        ap   = a;
        e = exp_code(c, b);
        model_update(c, b, a, e);
        for (int i = 0; i < NB; i++) eo[i] = row[i] || busy_m(i, cyc + 1);
        @(negedge clk);
        chk(vcode == e[2:0] && viol == (e != 0), tag, "reason code", int'(vcode), e);
        chk(bopen == eo, tag, "bank status", int'(bopen), int'(eo));
        cyc++;
    endtask

    task automatic nops(int n);
        for (int k = 0; k < n; k++) step(NOP, 0, 0, "R7");
    endtask

    task automatic closeall(string tag);
        nops(24);
        for (int i = 0; i < NB; i++) step(PRE, i, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            ap_t[i] = -1000; ap_r[i] = 0; ap_w[i] = 0; row[i] = 0;
        end
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(viol == 1'b0 && vcode == 3'd0, "R1", "reset verdict", int'(vcode), 0);
        chk(bopen == 4'd0, "R1", "reset status", int'(bopen), 0);

        // R2: basic open/close rules
        step(ACT, 0, 0, "R2"); step(ACT, 0, 0, "R2"); step(RD, 2, 0, "R2");
        step(PRE, 0, 0, "R2"); step(PRE, 3, 0, "R2");
        // R3: write-AP then read other bank (CL 2.5, BL 4, tWTR 2 -> 5 clocks)
        closeall("R2");
        step(ACT, 0, 0, "R3"); step(ACT, 1, 0, "R3"); step(WR, 0, 1, "R3");
        step(RD, 1, 0, "R3"); nops(2); step(RD, 1, 0, "R3"); step(RD, 1, 0, "R3");
        // R4: write-AP then write other bank (2 clocks)
        closeall("R4");
        step(ACT, 2, 0, "R4"); step(ACT, 3, 0, "R4"); step(WR, 2, 1, "R4");
        step(WR, 3, 0, "R4"); step(WR, 3, 0, "R4");
        // R5: read-AP then read, then read-AP then write
        closeall("R5");
        step(ACT, 0, 0, "R5"); step(ACT, 1, 0, "R5"); step(RD, 0, 1, "R5");
        step(RD, 1, 0, "R5"); step(RD, 1, 0, "R5");
        closeall("R5");
        step(ACT, 0, 0, "R5"); step(ACT, 1, 0, "R5"); step(RD, 0, 1, "R5");
        nops(2); step(WR, 1, 0, "R5"); step(NOP, 0, 0, "R5"); step(WR, 1, 0, "R5");
        // R6, R7: other-bank PRE/ACT right away; closing bank refuses commands
        closeall("R6");
        step(ACT, 0, 0, "R6"); step(WR, 0, 1, "R6"); step(PRE, 1, 0, "R6");
        step(ACT, 2, 0, "R6"); step(ACT, 0, 0, "R7"); step(RD, 0, 0, "R7");
        step(BST, 0, 0, "R7"); step(PRE, 0, 0, "R7");
        // R8: refresh / mode load only when idle
        nops(24);
        step(REF, 0, 0, "R8"); step(LMR, 1, 0, "R8");
        closeall("R8");
        step(REF, 0, 0, "R8"); step(LMR, 0, 0, "R8");
        // R9: terminate rules
        step(ACT, 0, 0, "R9"); step(ACT, 1, 0, "R9"); step(RD, 0, 0, "R9");
        step(BST, 1, 0, "R9"); step(BST, 0, 0, "R9"); step(WR, 1, 0, "R9");
        // R10: contention without terminate
        nops(24);
        step(RD, 0, 0, "R10"); step(WR, 1, 0, "R10"); nops(10);
        step(WR, 0, 0, "R10"); step(RD, 1, 0, "R10");
        // R11: priority and dropped commands
        closeall("R11");
        step(ACT, 1, 0, "R11"); step(ACT, 0, 0, "R11"); step(WR, 0, 1, "R11");
        step(RD, 2, 0, "R11"); step(REF, 0, 0, "R11"); step(RD, 1, 0, "R11");
        // R12: other settings (CL 2, BL 16, tWTR 1)
        closeall("R12");
        clh = 3'd4; bls = 2'd3; twtr = 2'd1;
        step(ACT, 0, 0, "R12"); step(ACT, 1, 0, "R12"); step(RD, 0, 1, "R12");
        nops(8); step(WR, 1, 0, "R12"); step(WR, 1, 0, "R12");
        closeall("R12");
        twtr = 2'd3;
        step(ACT, 2, 0, "R12"); step(ACT, 3, 0, "R12"); step(WR, 2, 1, "R12");
        nops(10); step(RD, 3, 0, "R12"); step(RD, 3, 0, "R12");

        // R11: seeded random traffic across settings
        for (int seg = 0; seg < 8; seg++) begin
            clh  = 3'(4 + ($urandom % 3));
            bls  = 2'($urandom % 4);
            twtr = 2'(1 + ($urandom % 3));
            for (int n = 0; n < 300; n++) begin
                int r;
                logic [2:0] c;
                r = $urandom % 16;
                if (r < 4)       c = ACT;
                else if (r < 7)  c = RD;
                else if (r < 10) c = WR;
                else if (r < 12) c = PRE;
                else if (r < 13) c = BST;
                else if (r < 14) c = ($urandom % 2) ? REF : LMR;
                else             c = NOP;
                step(c, int'($urandom % 4), bit'($urandom % 2), "R11");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule